// File: doc/BRIEF.md
# Receive Event Status Flag Controller

This block gathers the sticky event and error indications of a frame-based serial receiver into a single 16-bit status word. The receive datapath hands it one-cycle strobes: a decoded frame with its type, tag, CRC verdict and end-of-frame verdict, expiries of the ping and frame watchdogs, and buffer conditions (a write into a full receive buffer, a software read of an empty one). Each strobe sets its own sticky bit. The block also raises a frame-overrun bit when a new data or error frame lands while the matching frame-received bit is still pending.

Software reaches the block through a small register port with four word addresses. Address 0 returns the status word and ignores writes. A write to address 1 forces bits to one. A write to address 2 clears bits. Address 3 holds the tag reference and tag mask used for the masked tag compare. A hardware set and a software clear of the same bit in the same cycle resolve in favour of the set, so no event is lost.

Top module: `rx_evt_status`

## Requirements
- R1: After reset the status word reads 0x0000 and the tag configuration register (address 3) reads 0x0000.
- R2: Bit 15 of the status word always reads 0, and writes to the status address (0) leave the status unchanged.
- R3: A write to address 1 sets every status bit whose data bit is 1, for bits 0 to 14. Data bits that are 0 have no effect.
- R4: A write to address 2 clears every status bit whose data bit is 1. Data bits that are 0 have no effect.
- R5: When a hardware event sets a bit in the same cycle that a clear write clears it, the bit ends up set.
- R6: A frame strobe with type 0 (ping), 1 (data) or 2 (error) that carries no error sets bit 9, 11 or 8 respectively. Type 3 is invalid and sets bit 3 (type error).
- R7: Bit 2 (CRC error) sets only for a data-type frame with crcOk low. Bit 4 (end-of-frame error) sets for any frame strobe with eofOk low.
- R8: Bit 6 (frame done) sets only for a frame whose type is valid, whose eofOk is high and, if it is a data frame, whose crcOk is high.
- R9: Bit 10 (frame overrun) sets when an error-free data frame arrives while bit 11 is already set, or when an error-free error frame arrives while bit 8 is already set. A ping frame never sets it.
- R10: Address 3 holds the reference tag in bits [3:0] and the mask in bits [7:4]. An error-free frame whose tag satisfies (tag & mask) == (ref & mask) sets bit 12 (ping), 13 (data) or 14 (error) according to its type.
- R11: pingWdExpire sets bit 0, frameWdExpire sets bit 1, bufWrFull sets bit 5 (buffer overrun) and bufRdEmpty sets bit 7 (buffer underrun).
- R12: A set status bit stays set until a clear write addresses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameValid | input | 1 | One-cycle strobe: a frame has been decoded |
| frameType | input | 2 | Type of the decoded frame: 0 ping, 1 data, 2 error, 3 invalid |
| frameTag | input | 4 | Tag carried by the decoded frame |
| crcOk | input | 1 | Received CRC matched the computed CRC |
| eofOk | input | 1 | End-of-frame pattern was valid |
| pingWdExpire | input | 1 | One-cycle strobe: ping watchdog expired |
| frameWdExpire | input | 1 | One-cycle strobe: frame watchdog expired |
| bufWrFull | input | 1 | One-cycle strobe: write into a full receive buffer |
| bufRdEmpty | input | 1 | One-cycle strobe: software read of an empty receive buffer |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 2 | Register word address (0 status, 1 force, 2 clear, 3 tag config) |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for regAddr, combinational |

## Verification
A hardware set and a software clear can hit the same bit in one cycle. The bench provokes this by asserting a watchdog strobe during a clear write to that bit, and by sending a clean data frame while bit 11 is pending and being cleared. It expects the bit to survive, and in the second case expects overrun to set as well. The frame decode is swept over every type, CRC and end-of-frame verdict and every tag value, under three tag configurations, and each result is compared with a status word the bench computes itself.

// File: rtl/rx_evt_pkg.sv
package rx_evt_pkg;
  localparam int STAT_W = 16;
  localparam int ADDR_W = 2;

  // status bit positions
  localparam int B_PING_WD  = 0;
  localparam int B_FRAME_WD = 1;
  localparam int B_CRC      = 2;
  localparam int B_TYPE     = 3;
  localparam int B_EOF      = 4;
  localparam int B_BUF_OVR  = 5;
  localparam int B_DONE     = 6;
  localparam int B_BUF_UND  = 7;
  localparam int B_ERR_RX   = 8;
  localparam int B_PING_RX  = 9;
  localparam int B_OVERRUN  = 10;
  localparam int B_DATA_RX  = 11;
  localparam int B_TAG_PING = 12;
  localparam int B_TAG_DATA = 13;
  localparam int B_TAG_ERR  = 14;
  localparam int B_RSVD     = 15;

  localparam logic [STAT_W-1:0] LIVE_MASK = {1'b0, {(STAT_W-1){1'b1}}};

  typedef enum logic [1:0] {
    FT_PING = 2'd0,
    FT_DATA = 2'd1,
    FT_ERR  = 2'd2,
    FT_BAD  = 2'd3
  } frameKind_e;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT  = 2'd0,
    A_FORCE = 2'd1,
    A_CLEAR = 2'd2,
    A_TAG   = 2'd3
  } regSel_e;

  localparam int NUM_KIND = 3;

  // strobes from control to the flag datapath
  typedef struct packed {
    logic [STAT_W-1:0] hwSet;
    logic [STAT_W-1:0] swForce;
    logic [STAT_W-1:0] swClear;
  } flagStrobe_t;

  function automatic int recvBit(input int kind);
    case (kind)
      0:       return B_PING_RX;
      1:       return B_DATA_RX;
      default: return B_ERR_RX;
    endcase
  endfunction

  function automatic int tagBit(input int kind);
    case (kind)
      0:       return B_TAG_PING;
      1:       return B_TAG_DATA;
      default: return B_TAG_ERR;
    endcase
  endfunction
endpackage

// File: rtl/rx_evt_tagcmp.sv
module rx_evt_tagcmp #(
  parameter int TAG_W = 4
) (
  input  logic [TAG_W-1:0] tagIn,
  input  logic [TAG_W-1:0] tagRef,
  input  logic [TAG_W-1:0] tagMask,
  output logic             hit
);
  logic [TAG_W-1:0] diff;
  assign diff = (tagIn ^ tagRef) & tagMask;
  assign hit  = (diff == '0);
endmodule

// File: rtl/rx_evt_ctrl.sv
module rx_evt_ctrl
  import rx_evt_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic [1:0]        frameType,
  input  logic [TAG_W-1:0]  frameTag,
  input  logic              crcOk,
  input  logic              eofOk,
  input  logic              pingWdExpire,
  input  logic              frameWdExpire,
  input  logic              bufWrFull,
  input  logic              bufRdEmpty,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [STAT_W-1:0] regWrData,
  input  logic [STAT_W-1:0] flagsQ,
  output flagStrobe_t       strobe,
  output logic [2*TAG_W-1:0] tagCfgQ
);
  localparam int CFG_W = 2 * TAG_W;

  logic tagWr, forceWr, clearWr;
  logic isBad, crcBad, frameGood, tagHit;
  logic [NUM_KIND-1:0] kindGood;
  logic [STAT_W-1:0] hwSet;
  logic unusedHi;

  assign tagWr   = regWrEn && (regAddr == A_TAG);
  assign forceWr = regWrEn && (regAddr == A_FORCE);
  assign clearWr = regWrEn && (regAddr == A_CLEAR);
  assign unusedHi = ^regWrData[STAT_W-1:CFG_W];

  // tag reference in the low half, mask in the high half
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      tagCfgQ <= '0;
    else if (tagWr) tagCfgQ <= regWrData[CFG_W-1:0];
  end

  rx_evt_tagcmp #(.TAG_W(TAG_W)) u_tagcmp (
    .tagIn   (frameTag),
    .tagRef  (tagCfgQ[TAG_W-1:0]),
    .tagMask (tagCfgQ[CFG_W-1:TAG_W]),
    .hit     (tagHit)
  );

  assign isBad     = (frameType == FT_BAD);
  assign crcBad    = (frameType == FT_DATA) && !crcOk;
  assign frameGood = frameValid && !isBad && eofOk && !crcBad;

  for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
    assign kindGood[k] = frameGood && (frameType == 2'(k));
  end

  always_comb begin
    hwSet = '0;
    hwSet[B_PING_WD]  = pingWdExpire;
    hwSet[B_FRAME_WD] = frameWdExpire;
    hwSet[B_CRC]      = frameValid && crcBad;
    hwSet[B_TYPE]     = frameValid && isBad;
    hwSet[B_EOF]      = frameValid && !eofOk;
    hwSet[B_BUF_OVR]  = bufWrFull;
    hwSet[B_DONE]     = frameGood;
    hwSet[B_BUF_UND]  = bufRdEmpty;
    for (int k = 0; k < NUM_KIND; k++) begin
      hwSet[recvBit(k)] = kindGood[k];
      hwSet[tagBit(k)]  = kindGood[k] && tagHit;
    end
    // overrun looks at the pending flag before this cycle's update
    hwSet[B_OVERRUN] = (kindGood[FT_DATA] && flagsQ[B_DATA_RX]) ||
                       (kindGood[FT_ERR]  && flagsQ[B_ERR_RX]);
  end

  always_comb begin
    strobe.hwSet   = hwSet & LIVE_MASK;
    strobe.swForce = forceWr ? (regWrData & LIVE_MASK) : '0;
    strobe.swClear = clearWr ? (regWrData & LIVE_MASK) : '0;
  end
endmodule

// File: rtl/rx_evt_flags.sv
module rx_evt_flags
  import rx_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       strobe,
  output logic [STAT_W-1:0] flagsQ
);
  for (genvar i = 0; i < STAT_W; i++) begin : g_cell
    if (i == B_RSVD) begin : g_rsvd
      logic unusedRsvd;
      assign unusedRsvd = strobe.hwSet[i] ^ strobe.swForce[i] ^ strobe.swClear[i];
      assign flagsQ[i] = 1'b0;
    end else begin : g_live
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) flagsQ[i] <= 1'b0;
        else       flagsQ[i] <= (flagsQ[i] & ~strobe.swClear[i]) |
                                strobe.hwSet[i] | strobe.swForce[i];
      end
    end
  end
endmodule

// File: rtl/rx_evt_status.sv
module rx_evt_status
  import rx_evt_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic [1:0]        frameType,
  input  logic [TAG_W-1:0]  frameTag,
  input  logic              crcOk,
  input  logic              eofOk,
  input  logic              pingWdExpire,
  input  logic              frameWdExpire,
  input  logic              bufWrFull,
  input  logic              bufRdEmpty,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData
);
  localparam int CFG_W = 2 * TAG_W;

  flagStrobe_t        strobe;
  logic [STAT_W-1:0]  flagsQ;
  logic [CFG_W-1:0]   tagCfgQ;

  rx_evt_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .frameValid    (frameValid),
    .frameType     (frameType),
    .frameTag      (frameTag),
    .crcOk         (crcOk),
    .eofOk         (eofOk),
    .pingWdExpire  (pingWdExpire),
    .frameWdExpire (frameWdExpire),
    .bufWrFull     (bufWrFull),
    .bufRdEmpty    (bufRdEmpty),
    .regWrEn       (regWrEn),
    .regAddr       (regAddr),
    .regWrData     (regWrData),
    .flagsQ        (flagsQ),
    .strobe        (strobe),
    .tagCfgQ       (tagCfgQ)
  );

  rx_evt_flags u_flags (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .flagsQ (flagsQ)
  );

  always_comb begin
    case (regAddr)
      A_STAT:  regRdData = flagsQ;
      A_TAG:   regRdData = {{(STAT_W-CFG_W){1'b0}}, tagCfgQ};
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/rx_evt_status_chk.sv
module rx_evt_status_chk
  import rx_evt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              frameValid,
  input logic [1:0]        frameType,
  input logic              crcOk,
  input logic              eofOk,
  input logic              pingWdExpire,
  input logic              frameWdExpire,
  input logic              bufWrFull,
  input logic              bufRdEmpty,
  input logic              regWrEn,
  input logic [1:0]        regAddr,
  input logic [15:0]       regWrData,
  input logic [15:0]       regRdData,
  input logic [15:0]       flagsQ
);
  logic frcWr, clrWr, hwAny;
  logic [15:0] clrMask;

  assign frcWr   = regWrEn && (regAddr == 2'd1);
  assign clrWr   = regWrEn && (regAddr == 2'd2);
  assign clrMask = clrWr ? regWrData : 16'h0000;
  assign hwAny   = frameValid | pingWdExpire | frameWdExpire | bufWrFull | bufRdEmpty;

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !flagsQ[B_RSVD] && !(regAddr == 2'd0 && regRdData[15]));

  p_force_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    frcWr |=> ((flagsQ & $past(regWrData) & LIVE_MASK) == ($past(regWrData) & LIVE_MASK)));

  p_clear_zeroes_r4: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && !hwAny) |=> ((flagsQ & $past(regWrData)) == 16'h0000));

  p_set_beats_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && regWrData[B_PING_WD] && pingWdExpire) |=> flagsQ[B_PING_WD]);

  p_crc_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && frameType == 2'd1 && !crcOk) |=> flagsQ[B_CRC]);

  p_done_blocked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !eofOk && !flagsQ[B_DONE] && !(frcWr && regWrData[B_DONE]))
      |=> !flagsQ[B_DONE]);

  p_overrun_r9: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && frameType == 2'd1 && crcOk && eofOk && flagsQ[B_DATA_RX])
      |=> flagsQ[B_OVERRUN]);

  p_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((($past(flagsQ) & ~$past(clrMask))) & ~flagsQ) == 16'h0000));
endmodule

bind rx_evt_status rx_evt_status_chk u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .frameValid    (frameValid),
  .frameType     (frameType),
  .crcOk         (crcOk),
  .eofOk         (eofOk),
  .pingWdExpire  (pingWdExpire),
  .frameWdExpire (frameWdExpire),
  .bufWrFull     (bufWrFull),
  .bufRdEmpty    (bufRdEmpty),
  .regWrEn       (regWrEn),
  .regAddr       (regAddr),
  .regWrData     (regWrData),
  .regRdData     (regRdData),
  .flagsQ        (flagsQ)
);

// File: tb/tb_rx_evt_status.sv
module tb_rx_evt_status;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameValid = 1'b0;
  logic [1:0] frameType = 2'd0;
  logic [3:0] frameTag = 4'd0;
  logic crcOk = 1'b1;
  logic eofOk = 1'b1;
  logic pingWdExpire = 1'b0;
  logic frameWdExpire = 1'b0;
  logic bufWrFull = 1'b0;
  logic bufRdEmpty = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [15:0] regWrData = 16'h0;
  logic [15:0] regRdData;

  int nRun = 0;
  int nFail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  rx_evt_status dut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameType(frameType),
    .frameTag(frameTag), .crcOk(crcOk), .eofOk(eofOk),
    .pingWdExpire(pingWdExpire), .frameWdExpire(frameWdExpire),
    .bufWrFull(bufWrFull), .bufRdEmpty(bufRdEmpty), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      nRun++; nFail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // inputs change at negedge; one call advances through the next posedge
  task automatic tick();
    @(posedge clk); @(negedge clk);
    frameValid = 0; pingWdExpire = 0; frameWdExpire = 0;
    bufWrFull = 0; bufRdEmpty = 0; regWrEn = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    regAddr = a; #1 v = regRdData;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    regWrEn = 1; regAddr = a; regWrData = d; tick();
  endtask

  task automatic frame(input int ft, input bit crc, input bit eof, input int tag);
    frameValid = 1; frameType = 2'(ft); crcOk = crc; eofOk = eof; frameTag = 4'(tag);
    tick();
  endtask

  function automatic logic [15:0] model(input int ft, input bit crc, input bit eof,
      input int tag, input int rf, input int mk, input logic [15:0] prev);
    logic [15:0] s;
    bit good;
    s = prev;
    good = (ft != 3) && eof && (ft != 1 || crc);
    if (ft == 3) s[3] = 1;
    if (!eof) s[4] = 1;
    if (ft == 1 && !crc) s[2] = 1;
    if (good) begin
      s[6] = 1;
      if (ft == 1 && prev[11]) s[10] = 1;
      if (ft == 2 && prev[8]) s[10] = 1;
      case (ft)
        0: s[9] = 1;
        1: s[11] = 1;
        default: s[8] = 1;
      endcase
      if (((tag & mk) == (rf & mk))) s[12 + ft] = 1;
    end
    return s;
  endfunction

  initial begin
    logic [15:0] v, e;
    int refs[3];
    int masks[3];
    refs = '{0, 10, 5};
    masks = '{0, 15, 3};
    @(negedge clk); @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset values
    rd(2'd0, v); check("R1 status", v, 16'h0000);
    rd(2'd3, v); check("R1 tagcfg", v, 16'h0000);

    // R2 status address is read-only, bit 15 stuck at 0
    wr(2'd0, 16'hFFFF); rd(2'd0, v); check("R2 write to status", v, 16'h0000);
    wr(2'd1, 16'hFFFF); rd(2'd0, v); check("R2/R3 force all", v, 16'h7FFF);

    // R4 clear with zeros and with a pattern
    wr(2'd2, 16'h0000); rd(2'd0, v); check("R4 clear zero", v, 16'h7FFF);
    wr(2'd2, 16'h00F0); rd(2'd0, v); check("R4 clear partial", v, 16'h7F0F);
    wr(2'd2, 16'hFFFF); rd(2'd0, v); check("R4 clear all", v, 16'h0000);

    // R3 force each bit alone
    for (int b = 0; b < 16; b++) begin
      wr(2'd1, 16'(1) << b); rd(2'd0, v);
      check("R3 force single", v, (16'(1) << b) & 16'h7FFF);
      wr(2'd2, 16'hFFFF);
    end
    wr(2'd1, 16'h0005); wr(2'd1, 16'h0000); rd(2'd0, v);
    check("R3 force zero", v, 16'h0005);
    wr(2'd2, 16'hFFFF);

    // R11 individual event inputs
    pingWdExpire = 1; tick(); rd(2'd0, v); check("R11 ping wd", v, 16'h0001);
    wr(2'd2, 16'hFFFF);
    frameWdExpire = 1; tick(); rd(2'd0, v); check("R11 frame wd", v, 16'h0002);
    wr(2'd2, 16'hFFFF);
    bufWrFull = 1; tick(); rd(2'd0, v); check("R11 buf overrun", v, 16'h0020);
    wr(2'd2, 16'hFFFF);
    bufRdEmpty = 1; tick(); rd(2'd0, v); check("R11 buf underrun", v, 16'h0080);

    // R12 stays set over idle cycles
    for (int i = 0; i < 5; i++) tick();
    rd(2'd0, v); check("R12 sticky", v, 16'h0080);
    wr(2'd2, 16'hFFFF);

    // R5 set and clear of the same bit in one cycle
    pingWdExpire = 1; wr(2'd2, 16'h0001); rd(2'd0, v); check("R5 set wins", v, 16'h0001);
    frameWdExpire = 1; wr(2'd2, 16'h0001); rd(2'd0, v); check("R5 other bit", v, 16'h0002);
    wr(2'd2, 16'hFFFF);
    wr(2'd1, 16'h0800);
    frameValid = 1; frameType = 2'd1; crcOk = 1; eofOk = 1; frameTag = 4'd0;
    wr(2'd2, 16'h0800); rd(2'd0, v); check("R5/R9 data vs clear", v, 16'h2C40);
    wr(2'd2, 16'hFFFF);

    // R9 overrun per frame type
    for (int ft = 0; ft < 3; ft++) begin
      e = 16'h0;
      for (int n = 0; n < 2; n++) begin
        frame(ft, 1, 1, 0);
        e = model(ft, 1, 1, 0, 0, 0, e);
        rd(2'd0, v); check("R9 repeat frame", v, e);
      end
      frame((ft + 1) % 3, 1, 1, 0);
      e = model((ft + 1) % 3, 1, 1, 0, 0, 0, e);
      rd(2'd0, v); check("R9 other type", v, e);
      wr(2'd2, 16'hFFFF);
    end

    // R6 R7 R8 R10 sweep over frame decode and tag configs
    for (int c = 0; c < 3; c++) begin
      wr(2'd3, 16'((masks[c] << 4) | refs[c]));
      rd(2'd3, v); check("R10 tag cfg", v, 16'((masks[c] << 4) | refs[c]));
      for (int ft = 0; ft < 4; ft++)
        for (int crc = 0; crc < 2; crc++)
          for (int eof = 0; eof < 2; eof++)
            for (int tg = 0; tg < 16; tg++) begin
              wr(2'd2, 16'hFFFF);
              frame(ft, crc[0], eof[0], tg);
              rd(2'd0, v);
              check("R6/R7/R8/R10 frame", v,
                    model(ft, crc[0], eof[0], tg, refs[c], masks[c], 16'h0));
            end
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule